// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the command front end of a 16-bit NOR-style flash. It watches bus write cycles, each an address and a data word, and tracks the multi-cycle command protocol that guards every operation. A two-write key prefix must come before any set-up command. Erase needs a second key prefix before its confirm write. When a sequence completes, the block raises a one-clock start strobe for a separate program/erase engine. With that strobe it presents the captured target addresses and data words.

The block also keeps the current read mode. The modes are array read, identifier/status read and query-table read. A neighbouring read path uses this mode to pick what a read returns. A write that breaks the expected sequence drops the interface back to array read and starts nothing. Erase suspend and resume are single-write commands. They are gated by the engine's erase-busy indication.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, read_mode is 0 (array read) and every start strobe is low.
- R2: The key prefix is data AAh at address 555h, then data 55h at address 2AAh. The query entry address is 55h. These address compares use only wr_addr[10:0]. Command compares use only wr_data[7:0].
- R3: Key prefix, then A0h, then one more write: prog_go pulses in the cycle after that fourth write. op_addr0 and op_data0 hold that write's address and data.
- R4: Key prefix, then 40h, then two writes: dprog_go pulses after the fifth write. op_addr0/op_data0 hold the fourth write and op_addr1/op_data1 hold the fifth.
- R5: Key prefix, 80h, key prefix, then 30h: blk_erase_go pulses after the sixth write, and op_addr0 holds that write's address.
- R6: The same erase sequence ending in 10h pulses bank_erase_go instead.
- R7: Any write that does not fit the expected step sets read_mode to 0, returns to the first step and starts nothing.
- R8: F0h sets read_mode to 0. This holds as a single write, after a key prefix, and while in query mode.
- R9: 98h at address 55h sets read_mode to 2. In mode 2 every write other than F0h is ignored: there is no strobe and no mode change.
- R10: Key prefix then 90h sets read_mode to 1.
- R11: A single B0h write pulses susp_go only while erase_busy is high and no suspend is pending. A later single 30h write then pulses resume_go once. Otherwise B0h and 30h are bad sequences.
- R12: While pec_busy is high at the set-up write, A0h, 40h, 80h and 60h are rejected as bad sequences, but 90h is still accepted.
- R13: Key prefix, then 60h, then one write: prot_go pulses after that write, with op_addr0/op_data0 capturing it.
- R14: Each start strobe is one clock wide, and at most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | A bus write is presented this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data word |
| pec_busy | input | 1 | Program/erase engine busy |
| erase_busy | input | 1 | An erase is running in the engine |
| read_mode | output | 2 | 0 array, 1 identifier/status, 2 query table |
| prog_go | output | 1 | Start single-word program |
| dprog_go | output | 1 | Start double-word program |
| blk_erase_go | output | 1 | Start block erase |
| bank_erase_go | output | 1 | Start bank erase |
| prot_go | output | 1 | Start protect/lock/configuration write |
| susp_go | output | 1 | Suspend the running erase |
| resume_go | output | 1 | Resume the suspended erase |
| op_addr0 | output | ADDR_W | First captured address |
| op_data0 | output | DATA_W | First captured data |
| op_addr1 | output | ADDR_W | Second captured address (double-word) |
| op_data1 | output | DATA_W | Second captured data (double-word) |

## Verification
A wrong step counter shows up at the ports as a strobe one write early or late. It can also show as a strobe after a broken prefix, or as a missing one. Every such fault appears in the cycle right after the write that should, or should not, complete a sequence. A lost or stuck suspend flag shows as a missing or doubled resume strobe on the next 30h write. A wrong mode register shows on read_mode one cycle after the offending write. That includes query mode leaking to array read on a non-reset write.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int KEY_W = 11;
    localparam int CMD_W = 8;

    localparam logic [KEY_W-1:0] A_KEY_A = 11'h555;
    localparam logic [KEY_W-1:0] A_KEY_B = 11'h2AA;
    localparam logic [KEY_W-1:0] A_QUERY = 11'h055;

    localparam logic [CMD_W-1:0] C_KEY_A    = 8'hAA;
    localparam logic [CMD_W-1:0] C_KEY_B    = 8'h55;
    localparam logic [CMD_W-1:0] C_PROG     = 8'hA0;
    localparam logic [CMD_W-1:0] C_DPROG    = 8'h40;
    localparam logic [CMD_W-1:0] C_ERASE    = 8'h80;
    localparam logic [CMD_W-1:0] C_IDENT    = 8'h90;
    localparam logic [CMD_W-1:0] C_PROT     = 8'h60;
    localparam logic [CMD_W-1:0] C_QUERY    = 8'h98;
    localparam logic [CMD_W-1:0] C_BLK_RES  = 8'h30;
    localparam logic [CMD_W-1:0] C_BANK     = 8'h10;
    localparam logic [CMD_W-1:0] C_SUSPEND  = 8'hB0;
    localparam logic [CMD_W-1:0] C_RESET    = 8'hF0;

    localparam int GO_N      = 7;
    localparam int GO_PROG   = 0;
    localparam int GO_DPROG  = 1;
    localparam int GO_BLK    = 2;
    localparam int GO_BANK   = 3;
    localparam int GO_PROT   = 4;
    localparam int GO_SUSP   = 5;
    localparam int GO_RESUME = 6;

    typedef enum logic [1:0] {
        RM_ARRAY = 2'd0,
        RM_IDENT = 2'd1,
        RM_QUERY = 2'd2
    } rd_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_KEY1  = 4'd1,
        ST_KEY2  = 4'd2,
        ST_PROG  = 4'd3,
        ST_DW1   = 4'd4,
        ST_DW2   = 4'd5,
        ST_EKEY0 = 4'd6,
        ST_EKEY1 = 4'd7,
        ST_ECONF = 4'd8,
        ST_PROT  = 4'd9
    } seq_st_e;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
    import flash_cmd_pkg::*;
(
    input  logic [KEY_W-1:0] addr_lo,
    input  logic [CMD_W-1:0] data_lo,
    output logic             key_a,
    output logic             key_b,
    output logic             query
);

    always_comb begin
        key_a = (addr_lo == A_KEY_A) && (data_lo == C_KEY_A);
        key_b = (addr_lo == A_KEY_B) && (data_lo == C_KEY_B);
        query = (addr_lo == A_QUERY) && (data_lo == C_QUERY);
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              key_a,
    input  logic              key_b,
    input  logic              query,
    input  logic              pec_busy,
    input  logic              erase_busy,
    output rd_mode_e          mode,
    output logic [GO_N-1:0]   go,
    output logic [ADDR_W-1:0] a0,
    output logic [DATA_W-1:0] d0,
    output logic [ADDR_W-1:0] a1,
    output logic [DATA_W-1:0] d1
);

    typedef struct packed {
        seq_st_e           st;
        rd_mode_e          mode;
        logic              susp;
        logic [GO_N-1:0]   go;
        logic [ADDR_W-1:0] a0;
        logic [DATA_W-1:0] d0;
        logic [ADDR_W-1:0] a1;
        logic [DATA_W-1:0] d1;
    } seq_t;

    seq_t       s_q, s_d;
    logic       bad_d;
    logic [CMD_W-1:0] cmd;

    assign cmd = wr_data[CMD_W-1:0];

    always_comb begin
        s_d    = s_q;
        s_d.go = '0;
        bad_d  = 1'b0;
        if (wr_en) begin
            if (s_q.mode == RM_QUERY) begin
                if (cmd == C_RESET) begin
                    s_d.mode = RM_ARRAY;
                    s_d.st   = ST_IDLE;
                end
            end else begin
                unique case (s_q.st)
                    ST_IDLE: begin
                        if (key_a) begin
                            s_d.st = ST_KEY1;
                        end else if (cmd == C_RESET) begin
                            s_d.mode = RM_ARRAY;
                        end else if (query) begin
                            s_d.mode = RM_QUERY;
                        end else if (cmd == C_SUSPEND && erase_busy && !s_q.susp) begin
                            s_d.go[GO_SUSP] = 1'b1;
                            s_d.susp        = 1'b1;
                        end else if (cmd == C_BLK_RES && s_q.susp) begin
                            s_d.go[GO_RESUME] = 1'b1;
                            s_d.susp          = 1'b0;
                        end else begin
                            bad_d = 1'b1;
                        end
                    end
                    ST_KEY1: begin
                        if (key_b) s_d.st = ST_KEY2;
                        else       bad_d  = 1'b1;
                    end
                    ST_KEY2: begin
                        s_d.st = ST_IDLE;
                        if (cmd == C_RESET) begin
                            s_d.mode = RM_ARRAY;
                        end else if (cmd == C_IDENT) begin
                            s_d.mode = RM_IDENT;
                        end else if (pec_busy) begin
                            bad_d = 1'b1;
                        end else if (cmd == C_PROG) begin
                            s_d.st = ST_PROG;
                        end else if (cmd == C_DPROG) begin
                            s_d.st = ST_DW1;
                        end else if (cmd == C_ERASE) begin
                            s_d.st = ST_EKEY0;
                        end else if (cmd == C_PROT) begin
                            s_d.st = ST_PROT;
                        end else begin
                            bad_d = 1'b1;
                        end
                    end
                    ST_PROG, ST_PROT: begin
                        s_d.a0   = wr_addr;
                        s_d.d0   = wr_data;
                        s_d.st   = ST_IDLE;
                        s_d.mode = RM_ARRAY;
                        if (s_q.st == ST_PROG) s_d.go[GO_PROG] = 1'b1;
                        else                   s_d.go[GO_PROT] = 1'b1;
                    end
                    ST_DW1: begin
                        s_d.a0 = wr_addr;
                        s_d.d0 = wr_data;
                        s_d.st = ST_DW2;
                    end
                    ST_DW2: begin
                        s_d.a1           = wr_addr;
                        s_d.d1           = wr_data;
                        s_d.st           = ST_IDLE;
                        s_d.mode         = RM_ARRAY;
                        s_d.go[GO_DPROG] = 1'b1;
                    end
                    ST_EKEY0: begin
                        if (key_a) s_d.st = ST_EKEY1;
                        else       bad_d  = 1'b1;
                    end
                    ST_EKEY1: begin
                        if (key_b) s_d.st = ST_ECONF;
                        else       bad_d  = 1'b1;
                    end
                    ST_ECONF: begin
                        if (cmd == C_BLK_RES || cmd == C_BANK) begin
                            s_d.a0   = wr_addr;
                            s_d.d0   = wr_data;
                            s_d.st   = ST_IDLE;
                            s_d.mode = RM_ARRAY;
                            if (cmd == C_BLK_RES) s_d.go[GO_BLK]  = 1'b1;
                            else                  s_d.go[GO_BANK] = 1'b1;
                        end else begin
                            bad_d = 1'b1;
                        end
                    end
                    default: bad_d = 1'b1;
                endcase
                if (bad_d) begin
                    s_d.st   = ST_IDLE;
                    s_d.mode = RM_ARRAY;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mode = s_q.mode;
    assign go   = s_q.go;
    assign a0   = s_q.a0;
    assign d0   = s_q.d0;
    assign a1   = s_q.a1;
    assign d1   = s_q.d1;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pec_busy,
    input  logic              erase_busy,
    output logic [1:0]        read_mode,
    output logic              prog_go,
    output logic              dprog_go,
    output logic              blk_erase_go,
    output logic              bank_erase_go,
    output logic              prot_go,
    output logic              susp_go,
    output logic              resume_go,
    output logic [ADDR_W-1:0] op_addr0,
    output logic [DATA_W-1:0] op_data0,
    output logic [ADDR_W-1:0] op_addr1,
    output logic [DATA_W-1:0] op_data1
);

    logic            key_a, key_b, query;
    rd_mode_e        mode;
    logic [GO_N-1:0] go;

    flash_cmd_match u_match (
        .addr_lo (wr_addr[KEY_W-1:0]),
        .data_lo (wr_data[CMD_W-1:0]),
        .key_a   (key_a),
        .key_b   (key_b),
        .query   (query)
    );

    flash_cmd_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .key_a      (key_a),
        .key_b      (key_b),
        .query      (query),
        .pec_busy   (pec_busy),
        .erase_busy (erase_busy),
        .mode       (mode),
        .go         (go),
        .a0         (op_addr0),
        .d0         (op_data0),
        .a1         (op_addr1),
        .d1         (op_data1)
    );

    assign read_mode     = mode;
    assign prog_go       = go[GO_PROG];
    assign dprog_go      = go[GO_DPROG];
    assign blk_erase_go  = go[GO_BLK];
    assign bank_erase_go = go[GO_BANK];
    assign prot_go       = go[GO_PROT];
    assign susp_go       = go[GO_SUSP];
    assign resume_go     = go[GO_RESUME];

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] cmd,
    input logic       erase_busy,
    input logic [1:0] read_mode,
    input logic       prog_go,
    input logic       dprog_go,
    input logic       blk_erase_go,
    input logic       bank_erase_go,
    input logic       prot_go,
    input logic       susp_go,
    input logic       resume_go
);

    logic [6:0] gos;
    assign gos = {resume_go, susp_go, prot_go, bank_erase_go, blk_erase_go, dprog_go, prog_go};

    AST_RESET_ARRAY: assert property (@(posedge clk) !rst_n |=> (read_mode == 2'd0 && gos == 7'd0)); // R1
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gos)); // R14
    AST_PROG_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n) prog_go |=> !prog_go); // R14
    AST_SUSP_GATED: assert property (@(posedge clk) disable iff (!rst_n) susp_go |-> $past(erase_busy)); // R11
    AST_QUERY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (read_mode == 2'd2 && !(wr_en && cmd == 8'hF0)) |=> (read_mode == 2'd2 && gos == 7'd0)); // R9
    AST_QUERY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (read_mode == 2'd2 && wr_en && cmd == 8'hF0) |=> read_mode == 2'd0); // R8

endmodule

bind flash_cmd_decoder flash_cmd_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .cmd           (wr_data[7:0]),
    .erase_busy    (erase_busy),
    .read_mode     (read_mode),
    .prog_go       (prog_go),
    .dprog_go      (dprog_go),
    .blk_erase_go  (blk_erase_go),
    .bank_erase_go (bank_erase_go),
    .prot_go       (prot_go),
    .susp_go       (susp_go),
    .resume_go     (resume_go)
);

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

    localparam int AW = 21;
    localparam int DW = 16;
    localparam int K_PROG = 0, K_DPROG = 1, K_BLK = 2, K_BANK = 3, K_PROT = 4, K_SUSP = 5, K_RES = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          pec_busy = 1'b0;
    logic          erase_busy = 1'b0;
    logic [1:0]    read_mode;
    logic          prog_go, dprog_go, blk_erase_go, bank_erase_go, prot_go, susp_go, resume_go;
    logic [AW-1:0] op_addr0, op_addr1;
    logic [DW-1:0] op_data0, op_data1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int            kind;
        logic [AW-1:0] a0;
        logic [DW-1:0] d0;
        logic [AW-1:0] a1;
        logic [DW-1:0] d1;
        string         req;
    } exp_t;

    exp_t expq[$];

    always #4 clk = ~clk;

    flash_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pec_busy(pec_busy), .erase_busy(erase_busy), .read_mode(read_mode),
        .prog_go(prog_go), .dprog_go(dprog_go), .blk_erase_go(blk_erase_go),
        .bank_erase_go(bank_erase_go), .prot_go(prot_go), .susp_go(susp_go),
        .resume_go(resume_go), .op_addr0(op_addr0), .op_data0(op_data0),
        .op_addr1(op_addr1), .op_data1(op_data1)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(21'h00555, 16'h00AA);
        wr(21'h002AA, 16'h0055);
    endtask

    task automatic push(input int k, input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                        input logic [AW-1:0] a1, input logic [DW-1:0] d1, input string req);
        exp_t e;
        e.kind = k; e.a0 = a0; e.d0 = d0; e.a1 = a1; e.d1 = d1; e.req = req;
        expq.push_back(e);
    endtask

    task automatic check_mode(input logic [1:0] exp, input string req);
        chk(read_mode == exp, req, "read_mode", {30'd0, read_mode}, {30'd0, exp});
    endtask

    task automatic drained(input string req);
        @(negedge clk);
        chk(expq.size() == 0, req, "pending expected strobes", expq.size(), 0);
    endtask

    // monitor / scoreboard
    logic [6:0] mon_prev = '0;
    always @(negedge clk) begin
        logic [6:0] p;
        exp_t e;
        int k;
        p = {resume_go, susp_go, prot_go, bank_erase_go, blk_erase_go, dprog_go, prog_go};
        if (rst_n && p != 7'd0) begin
            if ($countones(p) != 1 || expq.size() == 0) begin
                chk(1'b0, "R14", "unexpected or multiple strobes", {25'd0, p}, 0);
            end else begin
                e = expq.pop_front();
                k = 0;
                for (int i = 0; i < 7; i++) if (p[i]) k = i;
                chk(k == e.kind, e.req, "strobe kind", k, e.kind);
                if (e.kind == K_PROG || e.kind == K_PROT || e.kind == K_DPROG) begin
                    chk(op_addr0 == e.a0, e.req, "op_addr0", {11'd0, op_addr0}, {11'd0, e.a0});
                    chk(op_data0 == e.d0, e.req, "op_data0", {16'd0, op_data0}, {16'd0, e.d0});
                end
                if (e.kind == K_DPROG) begin
                    chk(op_addr1 == e.a1, e.req, "op_addr1", {11'd0, op_addr1}, {11'd0, e.a1});
                    chk(op_data1 == e.d1, e.req, "op_data1", {16'd0, op_data1}, {16'd0, e.d1});
                end
                if (e.kind == K_BLK || e.kind == K_BANK)
                    chk(op_addr0 == e.a0, e.req, "erase address", {11'd0, op_addr0}, {11'd0, e.a0});
            end
            if ((p & mon_prev) != 7'd0)
                chk(1'b0, "R14", "strobe wider than one clock", {25'd0, p}, 0);
        end
        mon_prev = p;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_mode(2'd0, "R1");
        chk({prog_go, dprog_go, blk_erase_go, bank_erase_go, prot_go, susp_go, resume_go} == 7'd0,
            "R1", "strobes in reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 program
        push(K_PROG, 21'h12345, 16'hBEEF, '0, '0, "R3");
        unlock(); wr(21'h00555, 16'h00A0); wr(21'h12345, 16'hBEEF);
        @(negedge clk);
        chk(prog_go == 1'b0, "R14", "prog_go second cycle", prog_go, 0);
        drained("R3");

        // R2 upper address and data bits ignored
        push(K_PROG, 21'h00777, 16'h5A5A, '0, '0, "R2");
        wr(21'h1FD55, 16'h12AA); wr(21'h0AAAA, 16'hFF55); wr(21'h00000, 16'h34A0);
        wr(21'h00777, 16'h5A5A);
        drained("R2");

        // R4 double-word program
        push(K_DPROG, 21'h01000, 16'h1111, 21'h01001, 16'h2222, "R4");
        unlock(); wr(21'h00555, 16'h0040); wr(21'h01000, 16'h1111); wr(21'h01001, 16'h2222);
        drained("R4");

        // R5 block erase
        push(K_BLK, 21'h0C000, '0, '0, '0, "R5");
        unlock(); wr(21'h00555, 16'h0080); unlock(); wr(21'h0C000, 16'h0030);
        drained("R5");

        // R6 bank erase
        push(K_BANK, 21'h10000, '0, '0, '0, "R6");
        unlock(); wr(21'h00555, 16'h0080); unlock(); wr(21'h10000, 16'h0010);
        drained("R6");

        // R10 identifier mode, R8 exits
        unlock(); wr(21'h00555, 16'h0090);
        check_mode(2'd1, "R10");
        wr(21'h00000, 16'h00F0);
        check_mode(2'd0, "R8");
        unlock(); wr(21'h00555, 16'h0090);
        unlock(); wr(21'h00555, 16'h00F0);
        check_mode(2'd0, "R8");

        // R7 bad sequences
        unlock(); wr(21'h00555, 16'h0090);
        wr(21'h00555, 16'h00AA); wr(21'h002AB, 16'h0055);
        check_mode(2'd0, "R7");
        unlock(); wr(21'h00555, 16'h0080); wr(21'h00555, 16'h00AA); wr(21'h002AA, 16'h0056);
        wr(21'h04000, 16'h0030);
        unlock(); wr(21'h00555, 16'h0077); wr(21'h00123, 16'h0001);
        check_mode(2'd0, "R7");
        drained("R7");

        // R9 query mode
        wr(21'h00055, 16'h0098);
        check_mode(2'd2, "R9");
        unlock(); wr(21'h00555, 16'h00A0); wr(21'h00200, 16'h1234);
        check_mode(2'd2, "R9");
        drained("R9");
        wr(21'h00000, 16'h00F0);
        check_mode(2'd0, "R8");
        wr(21'h7F855, 16'h0098);
        check_mode(2'd2, "R2");
        wr(21'h00000, 16'h00F0);
        wr(21'h00056, 16'h0098);
        check_mode(2'd0, "R9");

        // R11 suspend / resume
        wr(21'h00000, 16'h00B0);
        drained("R11");
        erase_busy = 1'b1;
        push(K_SUSP, '0, '0, '0, '0, "R11");
        wr(21'h00000, 16'h00B0);
        wr(21'h00000, 16'h00B0);
        erase_busy = 1'b0;
        push(K_RES, '0, '0, '0, '0, "R11");
        wr(21'h00000, 16'h0030);
        wr(21'h00000, 16'h0030);
        drained("R11");

        // R12 busy gating
        pec_busy = 1'b1;
        unlock(); wr(21'h00555, 16'h00A0); wr(21'h00300, 16'h4321);
        unlock(); wr(21'h00555, 16'h0080); unlock(); wr(21'h0C000, 16'h0030);
        drained("R12");
        unlock(); wr(21'h00555, 16'h0090);
        check_mode(2'd1, "R12");
        wr(21'h00000, 16'h00F0);
        pec_busy = 1'b0;

        // R13 protect/configuration
        push(K_PROT, 21'h00400, 16'h0001, '0, '0, "R13");
        unlock(); wr(21'h00555, 16'h0060); wr(21'h00400, 16'h0001);
        drained("R13");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule